// File: doc/BRIEF.md
# Big-Integer Operand Packer

This block turns a big-endian byte stream holding one operand of a modular exponentiation (an exponent or a modulus) into 32-bit words. A software or DMA front end pulses a start strobe with the operand's byte count. It then supplies the bytes most significant first, one per cycle in which the input valid is high. Leading zero bytes are dropped. The remaining bytes are grouped into words so that the least significant byte of the operand always ends up in the low byte of word 0. Any partial group therefore sits in the most significant word, padded with zeros in its upper bytes.

Words leave on a simple write port (valid, index, data). The most significant word comes first, with the highest index, and the index counts down to 0. At the same time the block computes the operand's exact significant bit length for a key-length field. An operand longer than the supported maximum is refused with an error flag and produces no writes. A done pulse marks the end of each operation.

Top module: `operand_packer`

## Requirements
- R1: A start with a byte count above MAX_BYTES (512) is refused. One cycle later done and err are high and bit_len is 0. No word is written, and any bytes offered afterwards are ignored. err stays high until the next accepted start, which clears it.
- R2: Zero bytes at the front of the stream are dropped. They produce no write and do not count toward the word count.
- R3: bit_len equals 8 × (bytes left after the dropped zeros) minus the number of leading zero bits of the first nonzero byte. It is valid from the cycle of the first write and holds until the next start.
- R4: The number of writes equals the remaining byte count divided by 4, rounded up.
- R5: When the remaining count is not a multiple of 4, the first word written carries the first nonzero bytes in its low-order byte lanes and zeros in its upper lanes.
- R6: The first write uses index (word count − 1). Each later write uses the previous index minus one, so the final write has index 0.
- R7: Within a word, a byte that arrives earlier occupies a more significant lane (bits 31:24 highest).
- R8: An operand whose bytes are all zero, or whose count is zero, ends with bit_len 0, no writes and err low. For count zero, done comes one cycle after start. Otherwise it comes one cycle after the last byte.
- R9: Each write appears one cycle after the edge that accepted the byte completing it. done is high in the same cycle as the final write, and only once per operation.
- R10: A start strobe while an operation is in progress is ignored. Input bytes offered while no operation is in progress are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start strobe, sampled when idle |
| byte_count_i | input | CNT_W (16) | Operand length in bytes, sampled with start |
| in_valid_i | input | 1 | Input byte valid |
| in_byte_i | input | 8 | Operand byte, most significant first |
| wr_valid_o | output | 1 | Word write strobe |
| wr_index_o | output | IDX_W (7) | Word index of the write |
| wr_data_o | output | 32 | Packed word |
| bit_len_o | output | BL_W (13) | Significant bit length of the operand |
| done_o | output | 1 | End-of-operation pulse |
| err_o | output | 1 | Operand too long |

## Verification
Some properties are checked by assertions on every cycle:
- No write occurs while err is high, and an error leaves bit_len at zero.
- Any write is accompanied by a nonzero bit length.
- A write that coincides with done targets index 0.
- The remaining-byte counter never reaches zero while busy.
- The byte-lane fill never exceeds a word.

Other behaviour can only be shown by the directed scenarios:
- The exact word values, including the zero padding of a partial first word.
- The full descending index sequence and the exact bit length.
- Ignoring leading zeros, stray starts and idle bytes.
- The all-zero and empty outcomes.

// File: rtl/opk_pkg.sv
// Shared types and helpers for the operand packer.
package opk_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } opk_state_e;

    // Number of zero bits above the highest set bit of a byte (8 for zero).
    function automatic logic [3:0] lead_zeros8(input logic [7:0] b);
        logic [3:0] n;
        logic       hit;
        n   = 4'd0;
        hit = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            if (!hit && !b[i]) n = n + 4'd1;
            else               hit = 1'b1;
        end
        return n;
    endfunction

endpackage

// File: rtl/opk_seq.sv
// Operation sequencer: accepts start, tracks bytes left and whether the
// first nonzero byte has been seen, and flags the payload bytes.
// Assumes byte_count_i is stable in the start cycle and CNT_W >= LEFT_W.
module opk_seq #(
    parameter int MAX_BYTES = 512,
    parameter int CNT_W     = 16,
    parameter int LEFT_W    = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [CNT_W-1:0]  byte_count_i,
    input  logic              in_valid_i,
    input  logic [7:0]        in_byte_i,
    output logic              launch_o,
    output logic              first_o,
    output logic              take_o,
    output logic [LEFT_W-1:0] rem_o,
    output logic              done_o,
    output logic              err_o
);
    import opk_pkg::*;

    opk_state_e        state_q;
    logic [LEFT_W-1:0] left_q;
    logic              seen_q;
    logic              done_q;
    logic              err_q;
    logic              accept;
    logic              over;
    logic              empty;

    // Decode of the current byte and start request.
    always_comb begin
        accept   = (state_q == ST_RUN) && in_valid_i;
        over     = byte_count_i > CNT_W'(MAX_BYTES);
        empty    = byte_count_i == '0;
        launch_o = (state_q == ST_IDLE) && start_i;
        first_o  = accept && !seen_q && (in_byte_i != 8'd0);
        take_o   = accept && (seen_q || (in_byte_i != 8'd0));
        rem_o    = left_q;
    end

    // Operation state, byte countdown, done and error flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            left_q  <= '0;
            seen_q  <= 1'b0;
            done_q  <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        err_q  <= over;
                        done_q <= over || empty;
                        if (!over && !empty) begin
                            state_q <= ST_RUN;
                            left_q  <= LEFT_W'(byte_count_i);
                            seen_q  <= 1'b0;
                        end
                    end
                end
                default: begin
                    if (in_valid_i) begin
                        left_q <= left_q - LEFT_W'(1);
                        if (in_byte_i != 8'd0) seen_q <= 1'b1;
                        if (left_q == LEFT_W'(1)) begin
                            state_q <= ST_IDLE;
                            done_q  <= 1'b1;
                        end
                    end
                end
            endcase
        end
    end

    assign done_o = done_q;
    assign err_o  = err_q;

    // The countdown must never be zero while an operation runs.
    assert_left_nonzero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN) |-> (left_q != '0));

endmodule

// File: rtl/opk_pack.sv
// Word packer: shifts payload bytes into a word, pre-filling the padding
// lanes of a partial top word, and writes words at descending indices.
// Assumes WORD_BYTES is a power of two, at least 2.
module opk_pack #(
    parameter int WORD_BYTES = 4,
    parameter int LEFT_W     = 10,
    parameter int IDX_W      = 7,
    localparam int SEL_W     = $clog2(WORD_BYTES),
    localparam int FILL_W    = SEL_W + 1,
    localparam int WORD_W    = 8 * WORD_BYTES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take_i,
    input  logic              first_i,
    input  logic [LEFT_W-1:0] rem_i,
    input  logic [7:0]        byte_i,
    output logic              wr_valid_o,
    output logic [IDX_W-1:0]  wr_index_o,
    output logic [WORD_W-1:0] wr_data_o
);
    logic [WORD_W-1:0] acc_q;
    logic [FILL_W-1:0] fill_q;
    logic [IDX_W-1:0]  idx_q;
    logic              wr_valid_q;
    logic [IDX_W-1:0]  wr_index_q;
    logic [WORD_W-1:0] wr_data_q;

    logic [SEL_W-1:0]  pad;
    logic [FILL_W-1:0] fill_next;
    logic [WORD_W-1:0] word_next;
    logic [IDX_W-1:0]  top_idx;
    logic [IDX_W-1:0]  idx_base;
    logic              emit;

    // Next lane fill, shifted word, starting index and emit decision.
    always_comb begin
        pad       = SEL_W'(0) - rem_i[SEL_W-1:0];
        fill_next = (first_i ? FILL_W'(pad) : fill_q) + FILL_W'(1);
        word_next = {(first_i ? WORD_W'(0) : acc_q) << 8} | WORD_W'(byte_i);
        top_idx   = IDX_W'((rem_i - LEFT_W'(1)) >> SEL_W);
        idx_base  = first_i ? top_idx : idx_q;
        emit      = take_i && (fill_next == FILL_W'(WORD_BYTES));
    end

    // Accumulator, fill count, index countdown and write register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q      <= '0;
            fill_q     <= '0;
            idx_q      <= '0;
            wr_valid_q <= 1'b0;
            wr_index_q <= '0;
            wr_data_q  <= '0;
        end else begin
            wr_valid_q <= emit;
            if (take_i) begin
                acc_q  <= word_next;
                fill_q <= emit ? '0 : fill_next;
                idx_q  <= emit ? idx_base - IDX_W'(1) : idx_base;
            end
            if (emit) begin
                wr_data_q  <= word_next;
                wr_index_q <= idx_base;
            end
        end
    end

    assign wr_valid_o = wr_valid_q;
    assign wr_index_o = wr_index_q;
    assign wr_data_o  = wr_data_q;

    // A partially filled word never holds a full word of lanes.
    assert_fill_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        fill_q < FILL_W'(WORD_BYTES));

endmodule

// File: rtl/opk_bitlen.sv
// Bit-length unit: cleared at each start, loaded once from the first
// nonzero byte and the number of bytes remaining at that point.
module opk_bitlen #(
    parameter int LEFT_W = 10,
    parameter int BL_W   = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch_i,
    input  logic              first_i,
    input  logic [LEFT_W-1:0] rem_i,
    input  logic [7:0]        byte_i,
    output logic [BL_W-1:0]   bit_len_o
);
    import opk_pkg::*;

    logic [BL_W-1:0] len_q;

    // Clear on start, load on the first significant byte.
    always_ff @(posedge clk) begin
        if (!rst_n)        len_q <= '0;
        else if (launch_i) len_q <= '0;
        else if (first_i)  len_q <= (BL_W'(rem_i) << 3) - BL_W'(lead_zeros8(byte_i));
    end

    assign bit_len_o = len_q;

endmodule

// File: rtl/operand_packer.sv
// Top level: packs a big-endian operand stream into indexed words and
// reports its significant bit length. Assumes one byte per valid cycle
// and no new start until done has been seen.
module operand_packer #(
    parameter int MAX_BYTES  = 512,
    parameter int WORD_BYTES = 4,
    parameter int CNT_W      = 16,
    localparam int LEFT_W    = $clog2(MAX_BYTES + 1),
    localparam int IDX_W     = $clog2(MAX_BYTES / WORD_BYTES),
    localparam int BL_W      = $clog2(MAX_BYTES * 8 + 1),
    localparam int WORD_W    = 8 * WORD_BYTES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [CNT_W-1:0]  byte_count_i,
    input  logic              in_valid_i,
    input  logic [7:0]        in_byte_i,
    output logic              wr_valid_o,
    output logic [IDX_W-1:0]  wr_index_o,
    output logic [WORD_W-1:0] wr_data_o,
    output logic [BL_W-1:0]   bit_len_o,
    output logic              done_o,
    output logic              err_o
);
    logic              launch;
    logic              first;
    logic              take;
    logic [LEFT_W-1:0] rem;

    opk_seq #(.MAX_BYTES(MAX_BYTES), .CNT_W(CNT_W), .LEFT_W(LEFT_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .byte_count_i(byte_count_i),
        .in_valid_i(in_valid_i), .in_byte_i(in_byte_i), .launch_o(launch),
        .first_o(first), .take_o(take), .rem_o(rem), .done_o(done_o), .err_o(err_o)
    );

    opk_pack #(.WORD_BYTES(WORD_BYTES), .LEFT_W(LEFT_W), .IDX_W(IDX_W)) u_pack (
        .clk(clk), .rst_n(rst_n), .take_i(take), .first_i(first), .rem_i(rem),
        .byte_i(in_byte_i), .wr_valid_o(wr_valid_o), .wr_index_o(wr_index_o),
        .wr_data_o(wr_data_o)
    );

    opk_bitlen #(.LEFT_W(LEFT_W), .BL_W(BL_W)) u_bitlen (
        .clk(clk), .rst_n(rst_n), .launch_i(launch), .first_i(first), .rem_i(rem),
        .byte_i(in_byte_i), .bit_len_o(bit_len_o)
    );

    // A refused operand never writes.
    assert_err_no_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> !wr_valid_o);

    // A refused operand reports no bit length.
    assert_err_zero_len_R1: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> (bit_len_o == '0));

    // Every write comes from a nonzero operand.
    assert_write_has_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid_o |-> (bit_len_o != '0));

    // The last write of an operation lands at index 0.
    assert_last_index_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && wr_valid_o) |-> (wr_index_o == '0));

endmodule

// File: tb/operand_packer_test.sv
// Directed bench for operand_packer: one task per scenario.
module operand_packer_test;
    localparam int MAXB = 512;
    localparam int CW   = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [CW-1:0] count = '0;
    logic          in_valid = 1'b0;
    logic [7:0]    in_byte = 8'd0;
    logic          wr_valid;
    logic [6:0]    wr_index;
    logic [31:0]   wr_data;
    logic [12:0]   bit_len;
    logic          done;
    logic          err;

    operand_packer uut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .byte_count_i(count),
        .in_valid_i(in_valid), .in_byte_i(in_byte), .wr_valid_o(wr_valid),
        .wr_index_o(wr_index), .wr_data_o(wr_data), .bit_len_o(bit_len),
        .done_o(done), .err_o(err)
    );

    always #2 clk = ~clk;

    int          n_checks = 0;
    int          n_fail = 0;
    logic [7:0]  op [0:599];
    int          got_n;
    logic [6:0]  got_idx [0:199];
    logic [31:0] got_data [0:199];
    int          done_n;
    bit          done_with_wr;

    // Record writes and done pulses between clock edges.
    always @(negedge clk) begin
        if (rst_n) begin
            if (wr_valid) begin
                if (got_n < 200) begin
                    got_idx[got_n]  = wr_index;
                    got_data[got_n] = wr_data;
                end
                got_n = got_n + 1;
            end
            if (done) begin
                done_n       = done_n + 1;
                done_with_wr = wr_valid;
            end
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic clear_mon();
        got_n = 0;
        done_n = 0;
        done_with_wr = 1'b0;
    endtask

    function automatic int clz8(input logic [7:0] b);
        for (int i = 7; i >= 0; i--) if (b[i]) return 7 - i;
        return 8;
    endfunction

    // Drive one operation of n bytes from op[], then compare with the model.
    task automatic run_op(input int n, input int gap, input int poke_at);
        int z;
        int rem;
        int wc;
        int pad;
        int p;
        logic [31:0] w;
        clear_mon();
        @(posedge clk); #1;
        start = 1'b1;
        count = CW'(n);
        @(posedge clk); #1;
        start = 1'b0;
        for (int i = 0; i < n; i++) begin
            in_valid = 1'b1;
            in_byte  = op[i];
            if (i == poke_at) begin
                start = 1'b1;
                count = '0;
            end
            @(posedge clk); #1;
            in_valid = 1'b0;
            start    = 1'b0;
            for (int g = 0; g < gap; g++) begin
                @(posedge clk); #1;
            end
        end
        repeat (3) @(posedge clk);
        #1;
        z = 0;
        while (z < n && z < 600 && op[z] == 8'd0) z++;
        rem = n - z;
        if (n > MAXB) begin
            check(err == 1'b1, "R1", "err", err, 1);
            check(got_n == 0, "R1", "write count", got_n, 0);
            check(bit_len == 0, "R1", "bit_len", bit_len, 0);
            check(done_n == 1, "R1", "done count", done_n, 1);
        end else begin
            check(err == 1'b0, "R1", "err", err, 0);
            check(done_n == 1, "R9", "done count", done_n, 1);
            if (rem == 0) begin
                check(got_n == 0, "R8", "write count", got_n, 0);
                check(bit_len == 0, "R8", "bit_len", bit_len, 0);
            end else begin
                wc  = (rem + 3) / 4;
                pad = (4 - rem % 4) % 4;
                check(bit_len == 13'(8 * rem - clz8(op[z])), "R3", "bit_len",
                      bit_len, 8 * rem - clz8(op[z]));
                check(got_n == wc, "R4", "write count", got_n, wc);
                check(done_with_wr == 1'b1, "R9", "done with final write", done_with_wr, 1);
                for (int j = 0; j < wc && j < got_n; j++) begin
                    w = '0;
                    for (int b = 0; b < 4; b++) begin
                        p = 4 * j + b - pad;
                        w = {w[23:0], (p < 0) ? 8'd0 : op[z + p]};
                    end
                    check(got_idx[j] == 7'(wc - 1 - j), "R6", "index", got_idx[j], wc - 1 - j);
                    check(got_data[j] == w, "R7", "word", got_data[j], w);
                end
            end
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(wr_valid == 0 && done == 0 && err == 0 && bit_len == 0, "R9",
              "reset outputs", {wr_valid, done, err, bit_len}, 0);
    endtask

    task automatic t_aligned();
        op[0] = 8'h81; op[1] = 8'h22; op[2] = 8'h33; op[3] = 8'h44;
        run_op(4, 0, -1);
    endtask

    // R2 and R5: leading zeros dropped, partial top word right-aligned.
    task automatic t_leading();
        op[0] = 8'h00; op[1] = 8'h00; op[2] = 8'h05; op[3] = 8'hAA;
        op[4] = 8'hBB; op[5] = 8'hCC; op[6] = 8'hDD;
        run_op(7, 0, -1);
        check(got_n == 2, "R2", "words after zero strip", got_n, 2);
        check(got_data[0] == 32'h0000_0005, "R5", "padded top word", got_data[0], 32'h5);
    endtask

    task automatic t_single();
        op[0] = 8'h01;
        run_op(1, 0, -1);
        check(bit_len == 13'd1, "R3", "single bit", bit_len, 1);
    endtask

    // Three significant bytes with idle gaps between bytes.
    task automatic t_gapped();
        op[0] = 8'h00; op[1] = 8'h7F; op[2] = 8'h10; op[3] = 8'h20;
        run_op(4, 2, -1);
        check(got_data[0] == 32'h007F_1020, "R5", "three-byte word", got_data[0], 32'h007F1020);
    endtask

    task automatic t_large();
        op[0] = 8'h3C;
        for (int i = 1; i < MAXB; i++) op[i] = 8'((i * 37 + 11) & 255);
        run_op(MAXB, 0, -1);
        check(bit_len == 13'd4094, "R3", "full-size bit_len", bit_len, 4094);
    endtask

    task automatic t_max_zeros();
        for (int i = 0; i < MAXB - 1; i++) op[i] = 8'h00;
        op[MAXB - 1] = 8'h80;
        run_op(MAXB, 0, -1);
        check(got_n == 1 && got_idx[0] == 0, "R2", "one word at index 0", got_n, 1);
    endtask

    task automatic t_over();
        for (int i = 0; i < MAXB + 1; i++) op[i] = 8'h5A;
        run_op(MAXB + 1, 0, -1);
    endtask

    task automatic t_allzero();
        for (int i = 0; i < 6; i++) op[i] = 8'h00;
        run_op(6, 0, -1);
        check(err == 0 && got_n == 0, "R8", "all-zero operand", got_n, 0);
    endtask

    task automatic t_empty();
        run_op(0, 0, -1);
        check(bit_len == 0 && got_n == 0, "R8", "empty operand", got_n, 0);
    endtask

    // R10: a start with count 0 mid-operation would add a done pulse.
    task automatic t_busy_start();
        for (int i = 0; i < 8; i++) op[i] = 8'(8'h11 * (i + 1));
        run_op(8, 0, 3);
        check(done_n == 1, "R10", "start while busy ignored", done_n, 1);
    endtask

    task automatic t_idle_bytes();
        clear_mon();
        for (int i = 0; i < 5; i++) begin
            @(posedge clk); #1;
            in_valid = 1'b1;
            in_byte  = 8'hF0;
        end
        @(posedge clk); #1;
        in_valid = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        check(got_n == 0 && done_n == 0, "R10", "idle bytes ignored", got_n + done_n, 0);
        check(bit_len == 0, "R10", "bit_len untouched", bit_len, 0);
    endtask

    initial begin
        clear_mon();
        repeat (4) @(posedge clk);
        #1;
        rst_n = 1'b1;
        t_reset();
        t_idle_bytes();
        t_aligned();
        t_leading();
        t_single();
        t_gapped();
        t_over();
        t_aligned();
        t_allzero();
        t_empty();
        t_busy_start();
        t_max_zeros();
        t_large();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule